// File: doc/BRIEF.md
# Image Sensor Frame Capture Receiver

This block sits on the host side of a sensor whose pixel array is read out in a fixed order. It watches three asynchronous signals from the sensor: a frame-start pulse, a data-valid strobe and an 8-bit data bus. It turns each frame into a stream of memory writes, each carrying an address and a data byte. The first three bytes of every frame are status (exposure high, exposure low, gain). They are held in output registers and never written to memory. The visible pixels are written at `row * width + column`. The black reference line that closes each frame goes to a separate region, flagged by `wr_black`.

Both strobe inputs are oversampled with the local clock, so the local clock must run at least four times the strobe rate. The transfer mode and the window code are sampled once, at each frame start. In byte mode one strobe carries one byte. In bit mode eight strobes carry one byte on data bit 0, most significant bit first. This applies to the status header as well.

The write port is valid/ready. A pending write holds its payload until `wr_ready` is seen high. The sensor cannot be stalled, so back-pressure is limited: the sink must accept each word before the next pixel arrives. A pixel that arrives while a word is still pending is discarded, and the error flag is raised.

Top module: `pix_frame_rx`

## Requirements
- R1: After reset, `wr_valid`, `frame_done` and `overrun` are 0, and `hdr_exp` and `hdr_gain` are 0.
- R2: Strobes that arrive while no frame is in progress (before the first frame start, or after a frame has completed) produce no writes.
- R3: The first three bytes after a frame start are exposure high, exposure low and gain, in that order. `hdr_exp` and `hdr_gain` change only after the third byte has arrived, and all together. The gain byte is passed through even when it is meaningless, as in digital mode.
- R4: Each visible pixel produces one write with `wr_black`=0, `wr_addr` = row*width + column (row and column counted from 0), and the received byte on `wr_data`.
- R5: The window code `win_sel` selects columns x lines as follows: 00 = WIDE x NARROW, 01 = NARROW x WIDE, 10 = NARROW x NARROW, 11 = WIDE x WIDE. With the default parameters WIDE=160 and NARROW=120.
- R6: When `serial_mode`=1 at frame start, each byte (header and pixel) is built from eight strobes using `din[0]` only, most significant bit first. `din[7:1]` is ignored.
- R7: After the last visible line, one line of window-width pixels is written with `wr_black`=1 and `wr_addr` = column.
- R8: `frame_done` is a single-cycle pulse, issued once per frame, in the same cycle the last black-line write is produced.
- R9: A frame start that arrives before the previous frame completed sets `overrun`, which stays set until reset. The new frame is then received normally, starting from its header.
- R10: While `wr_valid`=1 and `wr_ready`=0, the payload holds. A pixel that arrives while a write is pending is discarded and sets `overrun`.
- R11: `win_sel` and `serial_mode` are sampled only at frame start. Changing them mid-frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs_in | input | 1 | Frame-start pulse from the sensor (asynchronous, active high) |
| dv_in | input | 1 | Data-valid strobe; data is taken on its rising edge |
| din | input | 8 | Sensor data bus |
| serial_mode | input | 1 | 1 = bit-serial on din[0], 0 = byte-parallel |
| win_sel | input | 2 | Window format code (see R5) |
| wr_ready | input | 1 | Write sink can accept |
| wr_valid | output | 1 | Write word is present |
| wr_black | output | 1 | Word belongs to the black reference region |
| wr_addr | output | AW (15) | Pixel address |
| wr_data | output | 8 | Pixel byte |
| hdr_exp | output | 16 | Last complete exposure value |
| hdr_gain | output | 8 | Last complete gain value |
| frame_done | output | 1 | One-cycle pulse at end of the black line |
| overrun | output | 1 | Sticky error: early frame start or discarded write |

## Verification
Some rules hold on every cycle and are checked by properties:
- a stalled write keeps its address, data and region flag;
- black-line addresses stay inside their region;
- image addresses stay inside the largest window;
- `frame_done` never lasts two cycles;
- the error flag never clears on its own.

Other behaviour needs whole frames and can only be shown by the bench scenarios, which compare every accepted write against a reference queue. This covers:
- the address order for each window code;
- MSB-first assembly in bit mode;
- the header updating only as a complete triple;
- configuration latched at frame start;
- recovery after an early frame start;
- the discarded word under back-pressure.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_IMG  = 2'd2,
    PH_BLK  = 2'd3
  } phase_t;

  // Window code 00 and 11 use the wide column count.
  function automatic logic code_wide_cols(input logic [1:0] code);
    return ~(code[1] ^ code[0]);
  endfunction

  // Window code 01 and 11 use the wide line count.
  function automatic logic code_tall_rows(input logic [1:0] code);
    return code[0];
  endfunction

endpackage

// File: rtl/fcr_sync.sv
module fcr_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], async_in[i]};
    end
    assign rise[i] = chain[STAGES-1] & ~chain[STAGES];
  end
endmodule

// File: rtl/fcr_deser.sv
module fcr_deser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       serial,
  input  logic       stb,
  input  logic [7:0] din,
  output logic       byte_vld,
  output logic [7:0] byte_out
);
  logic [2:0] bit_cnt;
  logic [6:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_out <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (clr) begin
        bit_cnt <= '0;
      end else if (stb) begin
        if (!serial) begin
          byte_vld <= 1'b1;
          byte_out <= din;
        end else begin
          shreg   <= {shreg[5:0], din[0]};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_vld <= 1'b1;
            byte_out <= {shreg, din[0]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/fcr_seq.sv
module fcr_seq
  import fcr_pkg::*;
#(
  parameter int WIDE   = 160,
  parameter int NARROW = 120,
  parameter int AW     = 15,
  parameter int CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs,
  input  logic [1:0]    win_sel,
  input  logic          serial_in,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  output logic          serial_q,
  output logic          push,
  output logic          push_black,
  output logic [AW-1:0] push_addr,
  output logic [7:0]    push_data,
  output logic [15:0]   hdr_exp,
  output logic [7:0]    hdr_gain,
  output logic          frame_done,
  output logic          late_fs
);
  localparam logic [CW-1:0] LAST_W = CW'(WIDE - 1);
  localparam logic [CW-1:0] LAST_N = CW'(NARROW - 1);
  localparam logic [AW-1:0] STEP_W = AW'(WIDE);
  localparam logic [AW-1:0] STEP_N = AW'(NARROW);

  phase_t        phase;
  logic          wide_q, tall_q;
  logic [1:0]    hidx;
  logic [7:0]    exp_hi, exp_lo;
  logic [CW-1:0] col, row;
  logic [AW-1:0] base;
  logic [CW-1:0] last_col, last_row;
  logic [AW-1:0] line_step;

  assign last_col  = wide_q ? LAST_W : LAST_N;
  assign last_row  = tall_q ? LAST_W : LAST_N;
  assign line_step = wide_q ? STEP_W : STEP_N;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      wide_q     <= 1'b1;
      tall_q     <= 1'b0;
      serial_q   <= 1'b0;
      hidx       <= '0;
      exp_hi     <= '0;
      exp_lo     <= '0;
      col        <= '0;
      row        <= '0;
      base       <= '0;
      push       <= 1'b0;
      push_black <= 1'b0;
      push_addr  <= '0;
      push_data  <= '0;
      hdr_exp    <= '0;
      hdr_gain   <= '0;
      frame_done <= 1'b0;
      late_fs    <= 1'b0;
    end else begin
      push       <= 1'b0;
      frame_done <= 1'b0;
      late_fs    <= 1'b0;
      if (fs) begin
        late_fs  <= (phase != PH_IDLE);
        phase    <= PH_HDR;
        hidx     <= '0;
        col      <= '0;
        row      <= '0;
        base     <= '0;
        wide_q   <= code_wide_cols(win_sel);
        tall_q   <= code_tall_rows(win_sel);
        serial_q <= serial_in;
      end else if (byte_vld) begin
        case (phase)
          PH_HDR: begin
            hidx <= hidx + 2'd1;
            case (hidx)
              2'd0:    exp_hi <= byte_in;
              2'd1:    exp_lo <= byte_in;
              default: begin
                hdr_exp  <= {exp_hi, exp_lo};
                hdr_gain <= byte_in;
                phase    <= PH_IMG;
              end
            endcase
          end
          PH_IMG: begin
            push       <= 1'b1;
            push_black <= 1'b0;
            push_addr  <= base + AW'(col);
            push_data  <= byte_in;
            if (col == last_col) begin
              col  <= '0;
              base <= base + line_step;
              if (row == last_row) phase <= PH_BLK;
              else                 row   <= row + CW'(1);
            end else begin
              col <= col + CW'(1);
            end
          end
          PH_BLK: begin
            push       <= 1'b1;
            push_black <= 1'b1;
            push_addr  <= AW'(col);
            push_data  <= byte_in;
            if (col == last_col) begin
              phase      <= PH_IDLE;
              frame_done <= 1'b1;
            end else begin
              col <= col + CW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fcr_wrport.sv
module fcr_wrport #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_black,
  input  logic [AW-1:0] push_addr,
  input  logic [7:0]    push_data,
  input  logic          wr_ready,
  output logic          wr_valid,
  output logic          wr_black,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          drop
);
  logic can_load;
  assign can_load = !wr_valid || wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_black <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      drop     <= 1'b0;
    end else begin
      drop <= push && !can_load;
      if (push && can_load) begin
        wr_valid <= 1'b1;
        wr_black <= push_black;
        wr_addr  <= push_addr;
        wr_data  <= push_data;
      end else if (wr_ready) begin
        wr_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pix_frame_rx.sv
module pix_frame_rx #(
  parameter int WIDE        = 160,
  parameter int NARROW      = 120,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(WIDE * WIDE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_in,
  input  logic          dv_in,
  input  logic [7:0]    din,
  input  logic          serial_mode,
  input  logic [1:0]    win_sel,
  input  logic          wr_ready,
  output logic          wr_valid,
  output logic          wr_black,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [15:0]   hdr_exp,
  output logic [7:0]    hdr_gain,
  output logic          frame_done,
  output logic          overrun
);
  localparam int CW = $clog2(WIDE);

  logic [1:0]    rises;
  logic          fs_rise, dv_rise;
  logic          serial_q;
  logic          byte_vld;
  logic [7:0]    byte_val;
  logic          push, push_black;
  logic [AW-1:0] push_addr;
  logic [7:0]    push_data;
  logic          late_fs, drop;

  fcr_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in({dv_in, fs_in}), .rise(rises)
  );
  assign fs_rise = rises[0];
  assign dv_rise = rises[1];

  fcr_deser u_deser (
    .clk(clk), .rst_n(rst_n), .clr(fs_rise), .serial(serial_q),
    .stb(dv_rise), .din(din), .byte_vld(byte_vld), .byte_out(byte_val)
  );

  fcr_seq #(.WIDE(WIDE), .NARROW(NARROW), .AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .fs(fs_rise), .win_sel(win_sel),
    .serial_in(serial_mode), .byte_vld(byte_vld), .byte_in(byte_val),
    .serial_q(serial_q), .push(push), .push_black(push_black),
    .push_addr(push_addr), .push_data(push_data), .hdr_exp(hdr_exp),
    .hdr_gain(hdr_gain), .frame_done(frame_done), .late_fs(late_fs)
  );

  fcr_wrport #(.AW(AW)) u_port (
    .clk(clk), .rst_n(rst_n), .push(push), .push_black(push_black),
    .push_addr(push_addr), .push_data(push_data), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_black(wr_black), .wr_addr(wr_addr),
    .wr_data(wr_data), .drop(drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               overrun <= 1'b0;
    else if (late_fs || drop) overrun <= 1'b1;
  end
endmodule

// File: rtl/pix_frame_rx_chk.sv
module pix_frame_rx_chk #(
  parameter int WIDE = 160,
  parameter int AW   = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_black,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          frame_done,
  input logic          overrun
);
  // R10: stalled word keeps its payload
  a_r10_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_black));

  // R7: black line stays inside its region
  a_r7_black_region: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_black |-> int'(wr_addr) < WIDE);

  // R4: image address inside the largest window
  a_r4_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_black |-> int'(wr_addr) < WIDE * WIDE);

  // R8: end-of-frame pulse is one cycle long
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R9: error flag is sticky
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind pix_frame_rx pix_frame_rx_chk #(.WIDE(WIDE), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_black(wr_black), .wr_addr(wr_addr), .wr_data(wr_data),
  .frame_done(frame_done), .overrun(overrun)
);

// File: tb/sim_pix_frame_rx.sv
module sim_pix_frame_rx;
  localparam int TW  = 8;
  localparam int TN  = 6;
  localparam int TAW = $clog2(TW * TW);

  logic clk = 0, rst_n = 0, fs_in = 0, dv_in = 0, serial_mode = 0, wr_ready = 1;
  logic [7:0] din = 0;
  logic [1:0] win_sel = 0;
  logic wr_valid, wr_black, frame_done, overrun;
  logic [TAW-1:0] wr_addr;
  logic [7:0] wr_data, hdr_gain;
  logic [15:0] hdr_exp;

  pix_frame_rx #(.WIDE(TW), .NARROW(TN)) u0 (
    .clk(clk), .rst_n(rst_n), .fs_in(fs_in), .dv_in(dv_in), .din(din),
    .serial_mode(serial_mode), .win_sel(win_sel), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_black(wr_black), .wr_addr(wr_addr),
    .wr_data(wr_data), .hdr_exp(hdr_exp), .hdr_gain(hdr_gain),
    .frame_done(frame_done), .overrun(overrun)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0, fd_cnt = 0, wr_cnt = 0, cyc = 0, ready_mode = 0;
  bit done = 0;
  logic [TAW+8:0] expq[$];
  logic [15:0] prev_exp = 0;
  logic [7:0]  prev_gain = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // reference comparison of every accepted write
  always @(negedge clk) begin
    cyc++;
    if (frame_done) fd_cnt++;
    if (rst_n && wr_valid && wr_ready) begin
      wr_cnt++;
      if (expq.size() == 0)
        chk(0, "R2", "unexpected write addr", wr_addr, -1);
      else begin
        logic [TAW+8:0] e;
        e = expq.pop_front();
        chk({wr_black, wr_addr, wr_data} == e, "R4/R7", "write word",
            {wr_black, wr_addr, wr_data}, e);
      end
    end
  end

  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0: wr_ready = 1;
      1: wr_ready = (cyc % 3) != 0;
      default: wr_ready = 0;
    endcase
  end

  task automatic strobe(input logic [7:0] v);
    @(negedge clk); din = v; dv_in = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); dv_in = 0;
    repeat (2) @(posedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit ser);
    if (!ser) strobe(v);
    else for (int i = 7; i >= 0; i--) strobe({7'h55, v[i]});
  endtask

  task automatic fstart();
    @(negedge clk); fs_in = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); fs_in = 0;
    repeat (3) @(posedge clk);
  endtask

  function automatic logic [7:0] pix(input int seed, input int r, input int c);
    return 8'((seed + r * 37 + c * 11) & 255);
  endfunction

  // stop_after < 0 : full frame
  task automatic run_frame(input logic [1:0] sel, input bit ser, input logic [15:0] ev,
                           input logic [7:0] g, input int seed, input int stop_after);
    int w, l, n, fd0;
    w = (sel == 2'b00 || sel == 2'b11) ? TW : TN;
    l = sel[0] ? TW : TN;
    n = 0;
    fd0 = fd_cnt;
    win_sel = sel; serial_mode = ser;
    fstart();
    send_byte(ev[15:8], ser);
    send_byte(ev[7:0], ser);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(hdr_exp == prev_exp && hdr_gain == prev_gain, "R3", "header before third byte",
        hdr_exp, prev_exp);
    send_byte(g, ser);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(hdr_exp == ev, "R3", "exposure", hdr_exp, ev);
    chk(hdr_gain == g, "R3", "gain", hdr_gain, g);
    prev_exp = ev; prev_gain = g;
    for (int r = 0; r < l; r++) begin
      for (int c = 0; c < w; c++) begin
        if (stop_after >= 0 && n >= stop_after) return;
        expq.push_back({1'b0, TAW'(r * w + c), pix(seed, r, c)});
        send_byte(pix(seed, r, c), ser);
        n++;
      end
      if (r == 0) begin win_sel = ~sel; serial_mode = ~ser; end // R11
    end
    for (int c = 0; c < w; c++) begin
      expq.push_back({1'b1, TAW'(c), pix(seed + 99, 0, c)});
      send_byte(pix(seed + 99, 0, c), ser);
    end
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(expq.size() == 0, "R5", "all writes of window delivered", expq.size(), 0);
    chk(fd_cnt == fd0 + 1, "R8", "one frame_done per frame", fd_cnt - fd0, 1);
    win_sel = sel; serial_mode = ser;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!wr_valid && !frame_done && !overrun, "R1", "reset outputs", wr_valid, 0);
    chk(hdr_exp == 0 && hdr_gain == 0, "R1", "reset header", hdr_exp, 0);
    rst_n = 1;
    // R2: strobes before any frame start
    for (int i = 0; i < 3; i++) strobe(8'h11 * i);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(wr_cnt == 0 && !wr_valid, "R2", "no write before frame start", wr_cnt, 0);
    // R4/R5 parallel, window code 00
    run_frame(2'b00, 0, 16'hA53C, 8'h21, 3, -1);
    // R2 after completion
    for (int i = 0; i < 2; i++) strobe(8'hEE);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(!wr_valid && expq.size() == 0, "R2", "no write after frame completed", wr_valid, 0);
    // R5/R11 window code 01, config flipped mid-frame
    run_frame(2'b01, 0, 16'h0102, 8'hF0, 17, -1);
    // R6 serial, window code 10
    run_frame(2'b10, 1, 16'h8E71, 8'h5A, 40, -1);
    // R5/R10 window code 11 with intermittent ready
    ready_mode = 1;
    run_frame(2'b11, 0, 16'h7FFE, 8'h03, 77, -1);
    ready_mode = 0;
    chk(overrun == 0, "R9", "no error on complete frames", overrun, 0);
    // R9 early frame start
    run_frame(2'b00, 0, 16'h1234, 8'h56, 5, 5);
    repeat (10) @(posedge clk);
    run_frame(2'b11, 0, 16'h4321, 8'h65, 9, -1);
    chk(overrun == 1, "R9", "early frame start flagged", overrun, 1);
    // R10 discarded write under stall
    rst_n = 0; expq.delete(); prev_exp = 0; prev_gain = 0;
    ready_mode = 2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!overrun && hdr_exp == 0, "R1", "second reset", overrun, 0);
    rst_n = 1; win_sel = 2'b00; serial_mode = 0;
    fstart();
    send_byte(8'h01, 0); send_byte(8'h02, 0); send_byte(8'h03, 0);
    expq.push_back({1'b0, TAW'(0), 8'hC4});
    send_byte(8'hC4, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(wr_valid && wr_addr == 0 && wr_data == 8'hC4, "R10", "first word pending", wr_data, 8'hC4);
    send_byte(8'h9B, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(overrun == 1, "R10", "discard sets error", overrun, 1);
    chk(wr_data == 8'hC4 && wr_addr == 0, "R10", "pending word kept", wr_data, 8'hC4);
    ready_mode = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(expq.size() == 0 && !wr_valid, "R10", "only first word delivered", expq.size(), 0);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule